// File: doc/BRIEF.md
# Context Status Event Ring Writer

This block records context status events for software. Each event is a 64-bit status word. The block places it in the next slot of a six-slot circular buffer and updates a pointer register that shows software where the newest entry lies. On request it then sends a single-cycle context-switch interrupt pulse. A caller that posts two events back to back can hold the interrupt back on the first one, so that software is woken only once, after the second.

After reset the write index holds the out-of-range value 7. Because of this, the first event after reset lands in slot 0 and not in slot 1. From then on the index steps through slots 0 to 5 and wraps.

Software reads the buffer and the pointer register through a 32-bit read port that uses word addresses. It moves its own read index by writing a field of the pointer register. The block stores that read index and shows it back, but never changes it on its own.

Top module: `csb_ring_writer`

## Requirements
- R1: The buffer has 6 slots of 64 bits, each kept as two 32-bit words. Word address 2n returns bits 31:0 of slot n and word address 2n+1 returns bits 63:32, so slot n starts at byte offset 8n.
- R2: After a synchronous reset the read index is 0, the write index is 7, irq_pulse is 0 and rd_data is 0.
- R3: An event accepted while the write index is 7 is stored in slot 0.
- R4: An event accepted while the write index is below 7 is stored in slot (index+1) mod 6, so slot 5 is followed by slot 0.
- R5: The write index changes to the slot just written on the same clock edge that stores the data. Without an event it does not change.
- R6: An event with ev_defer=0 makes irq_pulse high for exactly one cycle, in the cycle after the strobe.
- R7: An event with ev_defer=1 produces no interrupt pulse.
- R8: Word address 12 returns the pointer register: read index in bits 2:0, write index in bits 10:8, all other bits 0. Word addresses 13 to 15 return 0. A read issued with rd_en is presented on rd_data in the following cycle.
- R9: A software pointer write loads bits 2:0 of sw_ptr_wdata into the read index and ignores all other bits. The block itself never changes the read index.
- R10: If an event and a software pointer write arrive in the same cycle, both take effect. The write index comes only from the event, and the read index comes from the software data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ev_valid | input | 1 | Event write strobe |
| ev_word | input | 64 | Status word to append |
| ev_defer | input | 1 | Suppress the interrupt for this event |
| sw_ptr_we | input | 1 | Software write to the pointer register |
| sw_ptr_wdata | input | 32 | Software write data; bits 2:0 form the read index |
| rd_en | input | 1 | Register read request |
| rd_addr | input | 4 | Word address of the read |
| rd_data | output | 32 | Read data, one cycle after rd_en |
| irq_pulse | output | 1 | Context-switch interrupt pulse |

## Verification
The bench builds the block with its default parameters: 6 slots, a 3-bit index, sentinel 7 and 32-bit halves. Under these values sixty-odd random events wrap the ring about ten times, so the step from slot 5 to slot 0 is reached many times. The sentinel is reached only through reset, so the bench also applies a reset partway through the run, which exercises the sentinel entry into slot 0 twice. Directed cases cover a deferred event followed directly by a normal one, an event and a pointer write in the same cycle, and reads from the unused addresses.

// File: rtl/csbw_pkg.sv
package csbw_pkg;
  typedef enum logic [1:0] {
    RSEL_NONE = 2'd0,
    RSEL_BUF  = 2'd1,
    RSEL_PTR  = 2'd2
  } rsel_e;
endpackage

// File: rtl/csbw_ptr_ctrl.sv
module csbw_ptr_ctrl #(
  parameter int DEPTH    = 6,
  parameter int PTR_W    = 3,
  parameter int SENTINEL = 7
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             adv,
  input  logic             sw_we,
  input  logic [PTR_W-1:0] sw_rptr,
  output logic [PTR_W-1:0] wptr,
  output logic [PTR_W-1:0] rptr,
  output logic [PTR_W-1:0] wr_idx
);
  localparam logic [PTR_W-1:0] SENT = PTR_W'(SENTINEL);
  localparam logic [PTR_W-1:0] LAST = PTR_W'(DEPTH - 1);

  // Slot that the next event will occupy.
  always_comb begin
    if (wptr == SENT || wptr == LAST) wr_idx = '0;
    else                              wr_idx = wptr + PTR_W'(1);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wptr <= SENT;
      rptr <= '0;
    end else begin
      if (adv)   wptr <= wr_idx;
      if (sw_we) rptr <= sw_rptr;
    end
  end
endmodule

// File: rtl/csbw_store.sv
module csbw_store #(
  parameter int DEPTH  = 6,
  parameter int HALF_W = 32,
  parameter int IDX_W  = 3
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                we,
  input  logic [IDX_W-1:0]    widx,
  input  logic [2*HALF_W-1:0] wdata,
  input  logic                re,
  input  logic [IDX_W-1:0]    ridx,
  input  logic                rhalf,
  output logic [HALF_W-1:0]   rdata
);
  logic [HALF_W-1:0] half_q [2];
  logic              hsel_q;

  // Two separate memories, one per 32-bit half, each in a form that maps to block RAM.
  for (genvar h = 0; h < 2; h++) begin : g_half
    logic [HALF_W-1:0] mem [DEPTH];
    always_ff @(posedge clk) begin
      if (we) mem[widx] <= wdata[h*HALF_W +: HALF_W];
      if (re) half_q[h] <= mem[ridx];
    end
  end

  always_ff @(posedge clk) begin
    if (rst)     hsel_q <= 1'b0;
    else if (re) hsel_q <= rhalf;
  end

  assign rdata = hsel_q ? half_q[1] : half_q[0];
endmodule

// File: rtl/csbw_irq.sv
module csbw_irq (
  input  logic clk,
  input  logic rst,
  input  logic fire,
  input  logic defer,
  output logic pulse
);
  always_ff @(posedge clk) begin
    if (rst) pulse <= 1'b0;
    else     pulse <= fire & ~defer;
  end
endmodule

// File: rtl/csb_ring_writer.sv
module csb_ring_writer #(
  parameter int DEPTH    = 6,
  parameter int PTR_W    = 3,
  parameter int SENTINEL = 7,
  parameter int HALF_W   = 32,
  parameter int ADDR_W   = 4,
  parameter int WP_LSB   = 8
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                ev_valid,
  input  logic [2*HALF_W-1:0] ev_word,
  input  logic                ev_defer,
  input  logic                sw_ptr_we,
  input  logic [HALF_W-1:0]   sw_ptr_wdata,
  input  logic                rd_en,
  input  logic [ADDR_W-1:0]   rd_addr,
  output logic [HALF_W-1:0]   rd_data,
  output logic                irq_pulse
);
  import csbw_pkg::*;

  localparam logic [ADDR_W-1:0] PTR_ADDR = ADDR_W'(2 * DEPTH);

  logic [PTR_W-1:0]  wptr_w, rptr_w, wr_idx_w;
  logic [HALF_W-1:0] buf_rdata;
  logic [HALF_W-1:0] ptr_word, ptr_q;
  rsel_e             rsel_d, rsel_q;
  logic              buf_re;

  csbw_ptr_ctrl #(.DEPTH(DEPTH), .PTR_W(PTR_W), .SENTINEL(SENTINEL)) u_ptr (
    .clk(clk), .rst(rst), .adv(ev_valid),
    .sw_we(sw_ptr_we), .sw_rptr(sw_ptr_wdata[PTR_W-1:0]),
    .wptr(wptr_w), .rptr(rptr_w), .wr_idx(wr_idx_w)
  );

  csbw_store #(.DEPTH(DEPTH), .HALF_W(HALF_W), .IDX_W(PTR_W)) u_store (
    .clk(clk), .rst(rst),
    .we(ev_valid), .widx(wr_idx_w), .wdata(ev_word),
    .re(buf_re), .ridx(PTR_W'(rd_addr >> 1)), .rhalf(rd_addr[0]),
    .rdata(buf_rdata)
  );

  csbw_irq u_irq (
    .clk(clk), .rst(rst), .fire(ev_valid), .defer(ev_defer), .pulse(irq_pulse)
  );

  // Pointer register layout: read index in the low field, write index in the upper field.
  always_comb begin
    ptr_word                   = '0;
    ptr_word[PTR_W-1:0]        = rptr_w;
    ptr_word[WP_LSB +: PTR_W]  = wptr_w;
  end

  always_comb begin
    rsel_d = RSEL_NONE;
    if (rd_en) begin
      if (rd_addr < PTR_ADDR)       rsel_d = RSEL_BUF;
      else if (rd_addr == PTR_ADDR) rsel_d = RSEL_PTR;
    end
  end
  assign buf_re = (rsel_d == RSEL_BUF);

  always_ff @(posedge clk) begin
    if (rst) begin
      rsel_q <= RSEL_NONE;
      ptr_q  <= '0;
    end else begin
      rsel_q <= rsel_d;
      if (rsel_d == RSEL_PTR) ptr_q <= ptr_word;
    end
  end

  always_comb begin
    case (rsel_q)
      RSEL_BUF: rd_data = buf_rdata;
      RSEL_PTR: rd_data = ptr_q;
      default:  rd_data = '0;
    endcase
  end
endmodule

// File: rtl/csbw_checker.sv
module csbw_checker #(
  parameter int DEPTH    = 6,
  parameter int PTR_W    = 3,
  parameter int SENTINEL = 7
) (
  input logic             clk,
  input logic             rst,
  input logic             ev_valid,
  input logic             ev_defer,
  input logic             sw_ptr_we,
  input logic             irq_pulse,
  input logic [PTR_W-1:0] wptr,
  input logic [PTR_W-1:0] rptr
);
  localparam logic [PTR_W-1:0] SENT = PTR_W'(SENTINEL);
  localparam logic [PTR_W-1:0] LAST = PTR_W'(DEPTH - 1);

  // R2: reset state of both indices and of the interrupt
  a_r2_reset_state: assert property (@(posedge clk)
    rst |=> (wptr == SENT && rptr == '0 && !irq_pulse));

  // R3: the sentinel is always followed by slot 0
  a_r3_sentinel_to_zero: assert property (@(posedge clk) disable iff (rst)
    (ev_valid && wptr == SENT) |=> (wptr == '0));

  // R4: modulo stepping through the ring
  a_r4_modulo_step: assert property (@(posedge clk) disable iff (rst)
    (ev_valid && wptr != SENT) |=>
      (wptr == (($past(wptr) == LAST) ? '0 : $past(wptr) + PTR_W'(1))));

  // R4: the write index is either a slot or the sentinel
  a_r4_index_range: assert property (@(posedge clk) disable iff (rst)
    (wptr <= LAST) || (wptr == SENT));

  // R5: the write index stays put without an event
  a_r5_hold: assert property (@(posedge clk) disable iff (rst)
    !ev_valid |=> $stable(wptr));

  // R6: an event that is not deferred raises the pulse
  a_r6_pulse: assert property (@(posedge clk) disable iff (rst)
    (ev_valid && !ev_defer) |=> irq_pulse);

  // R7: no pulse unless an event without deferral came before it
  a_r7_no_pulse: assert property (@(posedge clk) disable iff (rst)
    !(ev_valid && !ev_defer) |=> !irq_pulse);

  // R9: only software moves the read index
  a_r9_rptr_owned: assert property (@(posedge clk) disable iff (rst)
    !sw_ptr_we |=> $stable(rptr));
endmodule

bind csb_ring_writer csbw_checker #(.DEPTH(DEPTH), .PTR_W(PTR_W), .SENTINEL(SENTINEL)) u_chk (
  .clk(clk), .rst(rst), .ev_valid(ev_valid), .ev_defer(ev_defer),
  .sw_ptr_we(sw_ptr_we), .irq_pulse(irq_pulse), .wptr(wptr_w), .rptr(rptr_w)
);

// File: tb/sim_csb_ring_writer.sv
module sim_csb_ring_writer;
  localparam int DEPTH = 6;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        ev_valid = 1'b0;
  logic [63:0] ev_word = '0;
  logic        ev_defer = 1'b0;
  logic        sw_ptr_we = 1'b0;
  logic [31:0] sw_ptr_wdata = '0;
  logic        rd_en = 1'b0;
  logic [3:0]  rd_addr = '0;
  logic [31:0] rd_data;
  logic        irq_pulse;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;
  int cyc = 0;

  logic [31:0] m_lo [DEPTH];
  logic [31:0] m_hi [DEPTH];
  bit          m_ok [DEPTH];
  int          m_wptr = 7;
  int          m_rptr = 0;

  always #5 clk = ~clk;

  csb_ring_writer u0 (
    .clk(clk), .rst(rst), .ev_valid(ev_valid), .ev_word(ev_word), .ev_defer(ev_defer),
    .sw_ptr_we(sw_ptr_we), .sw_ptr_wdata(sw_ptr_wdata), .rd_en(rd_en), .rd_addr(rd_addr),
    .rd_data(rd_data), .irq_pulse(irq_pulse)
  );

  function automatic int f_next(input int w);
    if (w == 7) return 0;
    return (w + 1) % DEPTH;
  endfunction

  function automatic logic [31:0] f_ptr(input int w, input int r);
    return (32'(w) << 8) | 32'(r);
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000 && !done) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual=%0d expected=<100000", cyc);
      finish_run();
    end
  end

  task automatic do_event(input logic [63:0] w, input logic d,
                          input logic swe, input logic [31:0] swd);
    int idx;
    @(negedge clk);
    ev_valid = 1'b1; ev_word = w; ev_defer = d;
    sw_ptr_we = swe; sw_ptr_wdata = swd;
    idx = f_next(m_wptr);
    m_lo[idx] = w[31:0]; m_hi[idx] = w[63:32]; m_ok[idx] = 1'b1;
    m_wptr = idx;
    if (swe) m_rptr = int'(swd[2:0]);
    @(negedge clk);
    ev_valid = 1'b0; sw_ptr_we = 1'b0;
    // R6 / R7: pulse follows the strobe by one cycle unless deferred
    chk(d ? "R7" : "R6", 32'(irq_pulse), 32'(!d));
  endtask

  task automatic idle_chk();
    @(negedge clk);
    chk("R6", 32'(irq_pulse), 32'd0);
  endtask

  task automatic rd(input logic [3:0] a, input logic [31:0] exp, input string req);
    @(negedge clk);
    rd_en = 1'b1; rd_addr = a;
    @(negedge clk);
    rd_en = 1'b0;
    chk(req, rd_data, exp);
  endtask

  task automatic sw_write(input logic [31:0] v);
    @(negedge clk);
    sw_ptr_we = 1'b1; sw_ptr_wdata = v;
    m_rptr = int'(v[2:0]);
    @(negedge clk);
    sw_ptr_we = 1'b0;
  endtask

  task automatic check_all();
    for (int i = 0; i < DEPTH; i++) begin
      if (m_ok[i]) begin
        rd(4'(2 * i), m_lo[i], "R1");
        rd(4'(2 * i + 1), m_hi[i], "R1");
      end
    end
    rd(4'd12, f_ptr(m_wptr, m_rptr), "R5");
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    @(negedge clk);
    rst = 1'b0;
    m_wptr = 7; m_rptr = 0;
  endtask

  initial begin
    void'($urandom(32'd1234));
    for (int i = 0; i < DEPTH; i++) m_ok[i] = 1'b0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R2: reset state
    chk("R2", 32'(irq_pulse), 32'd0);
    chk("R2", rd_data, 32'd0);
    rd(4'd12, 32'h0000_0700, "R2");
    // R3: first event goes to slot 0
    do_event(64'h1111_2222_3333_4444, 1'b0, 1'b0, '0);
    idle_chk();
    rd(4'd12, 32'h0000_0000, "R3");
    rd(4'd0, 32'h3333_4444, "R3");
    rd(4'd1, 32'h1111_2222, "R1");
    // R8: unused addresses read zero
    rd(4'd13, 32'd0, "R8");
    rd(4'd15, 32'd0, "R8");
    // R9: software moves read index; upper bits ignored
    sw_write(32'hFFFF_FF05);
    rd(4'd12, f_ptr(m_wptr, 5), "R9");
    // R7 then R6: deferred event followed directly by a normal one
    do_event(64'hAAAA_0001_BBBB_0001, 1'b1, 1'b0, '0);
    do_event(64'hAAAA_0002_BBBB_0002, 1'b0, 1'b0, '0);
    idle_chk();
    rd(4'd12, f_ptr(2, 5), "R4");
    // R10: event and pointer write in the same cycle
    do_event(64'hC0DE_0003_C0DE_0003, 1'b0, 1'b1, 32'h0000_0702);
    idle_chk();
    rd(4'd12, f_ptr(3, 2), "R10");
    // Random events: wrap the ring many times (R4, R5)
    for (int n = 0; n < 64; n++) begin
      logic [63:0] w;
      logic        d, swe;
      w   = {$urandom, $urandom};
      d   = ($urandom % 3) == 0;
      swe = ($urandom % 8) == 0;
      do_event(w, d, swe, $urandom);
      if (($urandom % 2) == 0) idle_chk();
      if ((n % 7) == 6) check_all();
    end
    check_all();
    // R4: explicit wrap from slot 5 to slot 0
    while (m_wptr != 4) do_event({$urandom, $urandom}, 1'b1, 1'b0, '0);
    do_event(64'h5555_5555_0000_0005, 1'b0, 1'b0, '0);
    rd(4'd12, f_ptr(5, m_rptr), "R4");
    do_event(64'h0000_0000_FFFF_0000, 1'b0, 1'b0, '0);
    rd(4'd12, f_ptr(0, m_rptr), "R4");
    rd(4'd0, 32'hFFFF_0000, "R4");
    rd(4'd11, 32'h5555_5555, "R1");
    // R2 / R3: reset partway through, sentinel again
    do_reset();
    rd(4'd12, 32'h0000_0700, "R2");
    do_event(64'h7777_8888_9999_AAAA, 1'b0, 1'b0, '0);
    rd(4'd12, 32'h0000_0000, "R3");
    rd(4'd0, 32'h9999_AAAA, "R3");
    check_all();
    finish_run();
  end
endmodule